// File: doc/BRIEF.md
# Phase-Accumulator Square-Wave Generator

This block produces a square wave on a single digital output line. It is clocked by the real-time I/O clock. A timed write port loads a frequency tuning word. On every tick that has no load, the tuning word is added to a wrapping phase accumulator. The accumulator's top bit is the output. The output frequency is therefore tuning_word × f_clk / 2^ACC_W.

A nonzero load does two things. It stores the new word, and it presets the accumulator to half scale. The output is then high in the cycle after the write edge, so the write fixes where the first rising edge falls. A load of zero is the stop command. It clears both the word and the accumulator, and the line stays low until the next nonzero load.

Words that are not powers of two give the right frequency on average. Individual edges wander by one clock cycle.

Top module: `clkgen_nco`

## Requirements
- R1: After reset the stored tuning word and the accumulator are zero and `clk_out` is low.
- R2: In a cycle without a load, the accumulator advances by the stored tuning word modulo 2^ACC_W (2^24 by default).
- R3: `clk_out` equals bit ACC_W-1 of the accumulator.
- R4: A write with `wr_en`=1, `wr_addr`=0 and nonzero `wr_data` stores the word and sets the accumulator to 0x800000 in place of accumulating. `clk_out` is then high from the cycle after that edge, and accumulation resumes on the following edge.
- R5: A tuning word of 2^k gives a period of exactly 2^(24-k) cycles, with 2^(23-k) cycles high and 2^(23-k) cycles low, starting high at the write.
- R6: A write of 0 to address 0 clears both the tuning word and the accumulator. `clk_out` is low from the next cycle and stays low until a nonzero load.
- R7: A write with `wr_addr` not equal to 0 changes neither the tuning word nor the accumulator's progress.
- R8: For a word that is not a power of two, the number of rising edges in N cycles after a load is within one of round(N·word/2^24). One-cycle edge jitter is allowed.
- R9: A nonzero load issued while the output is already toggling restarts the phase at half scale in the same way as R4, whatever the accumulator held.
- R10: The accumulator wraps through 2^24 without saturating, including for the largest word 0xFFFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Real-time I/O clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Timed write strobe |
| wr_addr | input | ADDR_W | Write address; only 0 is decoded |
| wr_data | input | ACC_W | Tuning word to load (0 = stop) |
| clk_out | output | 1 | Generated square wave |

## Verification
A load and the per-tick accumulation can fall in the same cycle. The load must win that cycle: the preset replaces the sum, and the sum resumes only on the next edge. The bench provokes the collision by writing in the middle of a running waveform. It writes the same word again, writes a different word, and writes zero, each at a point where the accumulator is neither zero nor half scale. It judges the outcome against a cycle-by-cycle reference of the accumulator, updated from the requirements, and it checks `clk_out` on every cycle after the write.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
    localparam int CG_ACC_W  = 24;
    localparam int CG_ADDR_W = 2;

    typedef enum logic [1:0] {
        CMD_RUN  = 2'd0,
        CMD_LOAD = 2'd1,
        CMD_STOP = 2'd2
    } cg_cmd_e;
endpackage

// File: rtl/clkgen_cmd_dec.sv
module clkgen_cmd_dec
    import clkgen_pkg::*;
#(
    parameter int ACC_W  = CG_ACC_W,
    parameter int ADDR_W = CG_ADDR_W
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ACC_W-1:0]  wr_data,
    output cg_cmd_e           cmd
);
    logic hit;

    always_comb begin
        hit = wr_en && (wr_addr == '0);
        cmd = CMD_RUN;
        if (hit) begin
            cmd = (wr_data == '0) ? CMD_STOP : CMD_LOAD;
        end
    end
endmodule

// File: rtl/clkgen_tword.sv
module clkgen_tword
    import clkgen_pkg::*;
#(
    parameter int ACC_W = CG_ACC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cg_cmd_e          cmd,
    input  logic [ACC_W-1:0] wr_data,
    output logic [ACC_W-1:0] tword
);
    typedef struct packed {
        logic [ACC_W-1:0] tw;
    } tw_state_t;

    tw_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (cmd)
            CMD_LOAD: st_d.tw = wr_data;
            CMD_STOP: st_d.tw = '0;
            default:  st_d.tw = st_q.tw;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tword = st_q.tw;

    // R7 / R1: the word only moves on a decoded load or stop
    assert_word_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_RUN) |=> $stable(tword));
    assert_stop_clears_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_STOP) |=> (tword == '0));
endmodule

// File: rtl/clkgen_phase.sv
module clkgen_phase
    import clkgen_pkg::*;
#(
    parameter int ACC_W = CG_ACC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cg_cmd_e          cmd,
    input  logic [ACC_W-1:0] tword,
    output logic             msb
);
    localparam logic [ACC_W-1:0] HALF_SCALE = {1'b1, {(ACC_W-1){1'b0}}};

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } ph_state_t;

    ph_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (cmd)
            CMD_LOAD: st_d.acc = HALF_SCALE;
            CMD_STOP: st_d.acc = '0;
            default:  st_d.acc = st_q.acc + tword;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign msb = st_q.acc[ACC_W-1];

    assert_preset_on_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_LOAD) |=> (st_q.acc == HALF_SCALE));
    assert_stop_clears_acc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_STOP) |=> (st_q.acc == '0));
    assert_accumulate_wraps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_RUN) |=> (st_q.acc == ACC_W'($past(st_q.acc) + $past(tword))));
endmodule

// File: rtl/clkgen_nco.sv
module clkgen_nco
    import clkgen_pkg::*;
#(
    parameter int ACC_W  = CG_ACC_W,
    parameter int ADDR_W = CG_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ACC_W-1:0]  wr_data,
    output logic              clk_out
);
    cg_cmd_e          cmd;
    logic [ACC_W-1:0] tword;

    clkgen_cmd_dec #(.ACC_W(ACC_W), .ADDR_W(ADDR_W)) u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cmd     (cmd)
    );

    clkgen_tword #(.ACC_W(ACC_W)) u_tword (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (cmd),
        .wr_data (wr_data),
        .tword   (tword)
    );

    clkgen_phase #(.ACC_W(ACC_W)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd   (cmd),
        .tword (tword),
        .msb   (clk_out)
    );

    // R6: a zero word means the line is parked low
    assert_stopped_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tword == '0) |-> !clk_out);
    // R4: any accepted nonzero load drives the line high on the next cycle
    assert_load_rises_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == '0 && wr_data != '0) |=> clk_out);
endmodule

// File: tb/sim_clkgen_nco.sv
module sim_clkgen_nco;
    localparam int AW = 24;
    localparam int DW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_addr = '0;
    logic [AW-1:0] wr_data = '0;
    logic          clk_out;

    int n_chk = 0;
    int n_bad = 0;
    logic [AW-1:0] m_acc = '0;
    logic [AW-1:0] m_tw = '0;
    bit done = 0;

    always #2.5 clk = ~clk;

    clkgen_nco #(.ACC_W(AW), .ADDR_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .clk_out(clk_out)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: clk_out=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive at negedge, let one posedge pass, update reference, compare at next negedge
    task automatic step(input logic en, input logic [DW-1:0] a,
                        input logic [AW-1:0] d, input string req);
        wr_en = en; wr_addr = a; wr_data = d;
        @(posedge clk);
        if (en && a == '0) begin
            m_tw  = d;
            m_acc = (d == '0) ? '0 : 24'h800000;
        end else begin
            m_acc = m_acc + m_tw;
        end
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        check(req, clk_out, m_acc[AW-1]);
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) step(1'b0, '0, '0, req);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1", clk_out, 1'b0);
        rst_n = 1'b1;
        idle(4, "R1");
    endtask

    task automatic t_pow2;
        int hi = 0;
        int rises = 0;
        logic prev;
        step(1'b1, '0, 24'h100000, "R4");
        check("R4", clk_out, 1'b1);
        prev = 1'b1;
        for (int i = 0; i < 31; i++) begin
            step(1'b0, '0, '0, "R5");
            if (clk_out) hi++;
            if (clk_out && !prev) rises++;
            prev = clk_out;
        end
        check_int("R5_high_cycles", hi + 1, 16);
        check_int("R5_rises", rises, 1);
    endtask

    task automatic t_restart;
        idle(5, "R2");
        step(1'b1, '0, 24'h100000, "R9");
        check("R9", clk_out, 1'b1);
        idle(11, "R9");
        step(1'b1, '0, 24'h040000, "R9");
        idle(40, "R3");
    endtask

    task automatic t_stop;
        idle(3, "R2");
        step(1'b1, '0, 24'h000000, "R6");
        check("R6", clk_out, 1'b0);
        idle(50, "R6");
    endtask

    task automatic t_badaddr;
        step(1'b1, 2'd1, 24'h400000, "R7");
        idle(20, "R7");
        check("R7_still_stopped", clk_out, 1'b0);
        step(1'b1, '0, 24'h080000, "R4");
        idle(7, "R7");
        step(1'b1, 2'd3, 24'h000000, "R7");
        idle(40, "R7");
    endtask

    task automatic t_jitter;
        int rises = 0;
        logic prev;
        step(1'b1, '0, 24'h000000, "R6");
        prev = clk_out;
        step(1'b1, '0, 24'h155555, "R8");
        if (clk_out && !prev) rises++;
        prev = clk_out;
        for (int i = 0; i < 1199; i++) begin
            step(1'b0, '0, '0, "R8");
            if (clk_out && !prev) rises++;
            prev = clk_out;
        end
        n_chk++;
        if (rises < 99 || rises > 101) begin
            n_bad++;
            $display("FAIL R8: rising edges %0d expected 100 +/- 1", rises);
        end
    endtask

    task automatic t_wrap;
        step(1'b1, '0, 24'hFFFFFF, "R10");
        idle(30, "R10");
        step(1'b1, '0, 24'h7FFFFF, "R10");
        idle(30, "R3");
    endtask

    initial begin
        t_reset();
        t_pow2();
        t_restart();
        t_stop();
        t_badaddr();
        t_jitter();
        t_wrap();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule